// File: doc/BRIEF.md
# Sub-page write-permission walker

This block decides whether a guest write into a 4 KB page may go ahead, at a granularity of 128-byte sub-pages, so each page carries 32 independent write-permission bits. A request carries the guest physical address, two bits taken from the leaf translation entry (the sub-page-protect bit and the writable bit) and the block-wide enable. The walker then either settles the request at once or walks a four-level permission table in memory, starting from a root page frame held in a configuration input.

The table walk uses a single outstanding read on a valid/ready request port with a one-beat response. At each directory level the returned entry is checked for reserved bits before its present bit is looked at. The leaf entry holds the permission bits for the page's sub-pages. Each request ends in exactly one outcome pulse: legacy handling, allow, permission violation, table miss or table misconfiguration. A miss comes with a qualification word that has only bit 11 set, and every other outcome's qualification word is zero.

Top module: `subpg_walker`

## Requirements
- R1: When the enable is low or the leaf's sub-page-protect bit is clear, an accepted request gives outcome LEGACY (code 0) in the cycle after acceptance and issues no memory read, even if the writable bit is set.
- R2: When the enable and the sub-page-protect bit are both set and the leaf's writable bit is set, the outcome is ALLOW (code 1) in the cycle after acceptance, with no memory read.
- R3: Otherwise the walker reads the table levels in the order L4, L3, L2, L1. Each read address is the 4 KB table frame followed by a 9-bit index and three zero bits. The index is GPA[47:39] for L4, [38:30] for L3, [29:21] for L2 and [20:12] for L1. The first frame is the root input, and each later frame is bits PA_W-1:12 of the previous entry.
- R4: A directory (L4/L3/L2) entry with any of bits 11:1 or bits 63:PA_W set ends the walk with MISCONF (code 4), even if its present bit 0 is clear. The qualification word is then zero.
- R5: A directory entry with no reserved bit set and bit 0 clear ends the walk with MISS (code 3), and the qualification word is exactly 0x800 (bit 11 alone).
- R6: An L1 entry with any odd bit (2i+1) set gives MISCONF.
- R7: Otherwise, with i = GPA[11:7], bit 2i of the L1 entry set gives ALLOW and clear gives VIOLATE (code 2). An all-zero L1 entry is a violation, not a miss.
- R8: Every accepted request produces exactly one single-cycle outcome pulse. req_ready is high only while the walker is idle, and it is low from acceptance until the outcome of a walk.
- R9: While a memory read is not accepted, mem_req_valid stays high and mem_req_addr stays unchanged.
- R10: During and right after reset, req_ready is high and out_valid and mem_req_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_gpa | input | 41 | Guest physical address bits 47:7 |
| req_leaf_subprot | input | 1 | Leaf translation entry's sub-page-protect bit |
| req_leaf_wr | input | 1 | Leaf translation entry's writable bit |
| cfg_subprot_en | input | 1 | Block-wide sub-page protection enable |
| cfg_root_pfn | input | PA_W-12 | Frame of the L4 table |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Table entry |
| out_valid | output | 1 | Outcome pulse |
| out_kind | output | 3 | Outcome code: 0 legacy, 1 allow, 2 violate, 3 miss, 4 misconf |
| out_qual | output | 64 | Qualification word (0x800 on miss, else zero) |

## Verification
The table-driven pass first sends requests that should settle without a walk: enable off, protect bit off, and writable set. These separate the two early exits from each other and from the walk. Full four-level walks then probe the lowest sub-page, the highest sub-page and neighbouring sub-pages, which shows that the permission bit is picked from GPA[11:7] and read at even positions. Walks that stop at each directory level, with a clear present bit, with reserved low bits while not present, and with the lowest reserved high bit against the highest address bit, show the check order and the frame extraction. Odd-bit leaves, an empty leaf and memory back-pressure cover the leaf checks and the hold rule.

// File: rtl/subpg_pkg.sv
package subpg_pkg;
   typedef enum logic [2:0] {
      OUT_LEGACY  = 3'd0,
      OUT_ALLOW   = 3'd1,
      OUT_VIOLATE = 3'd2,
      OUT_MISS    = 3'd3,
      OUT_MISCONF = 3'd4
   } outcome_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } walk_state_e;

   localparam int ENTRY_W   = 64;
   localparam int ENTRY_LOG = 3;
   localparam int MISS_QUAL_BIT = 11;
endpackage

// File: rtl/subpg_entry_addr.sv
// Forms the byte address of the entry for the current level.
module subpg_entry_addr #(
   parameter int PA_W     = 46,
   parameter int LEVELS   = 4,
   parameter int IDX_W    = 9,
   parameter int PAGE_LOG = 12,
   localparam int GPA_W   = PAGE_LOG + LEVELS * IDX_W,
   localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1,
   localparam int PFN_W   = PA_W - PAGE_LOG
) (
   input  logic [GPA_W-1:PAGE_LOG] gpa_pg,
   input  logic [LVL_W-1:0]        lvl,
   input  logic [PFN_W-1:0]        base_pfn,
   output logic [PA_W-1:0]         addr
);
   import subpg_pkg::*;

   logic [IDX_W-1:0] idx_tab [LEVELS];

   // level 0 is the leaf table, level LEVELS-1 the root table
   for (genvar g = 0; g < LEVELS; g++) begin : g_idx
      assign idx_tab[g] = gpa_pg[PAGE_LOG + g*IDX_W +: IDX_W];
   end

   assign addr = {base_pfn, idx_tab[lvl], {ENTRY_LOG{1'b0}}};
endmodule

// File: rtl/subpg_dir_check.sv
// Classifies an L4/L3/L2 entry: reserved bits, present flag, next frame.
module subpg_dir_check #(
   parameter int PA_W     = 46,
   parameter int PAGE_LOG = 12,
   localparam int PFN_W   = PA_W - PAGE_LOG
) (
   input  logic [63:0]      ent,
   output logic             misconf,
   output logic             present,
   output logic [PFN_W-1:0] next_pfn
);
   localparam logic [63:0] ADDR_MASK = (64'd1 << PA_W) - 64'd1;
   localparam logic [63:0] LOW_MASK  = (64'd1 << PAGE_LOG) - 64'd1;
   localparam logic [63:0] RSV_MASK  = ~ADDR_MASK | (LOW_MASK & ~64'd1);

   assign misconf  = |(ent & RSV_MASK);
   assign present  = ent[0];
   assign next_pfn = ent[PA_W-1:PAGE_LOG];
endmodule

// File: rtl/subpg_leaf_check.sv
// Splits an L1 entry into permission (even) and reserved (odd) bits.
module subpg_leaf_check #(
   parameter int SUB_IDX_W = 5,
   localparam int SUBS     = 1 << SUB_IDX_W
) (
   input  logic [2*SUBS-1:0]    ent,
   input  logic [SUB_IDX_W-1:0] sub,
   output logic                 misconf,
   output logic                 perm
);
   logic [SUBS-1:0] perm_v;
   logic [SUBS-1:0] rsv_v;

   for (genvar g = 0; g < SUBS; g++) begin : g_sub
      assign perm_v[g] = ent[2*g];
      assign rsv_v[g]  = ent[2*g+1];
   end

   assign misconf = |rsv_v;
   assign perm    = perm_v[sub];
endmodule

// File: rtl/subpg_walker.sv
// Sub-page write-permission walker top.
module subpg_walker #(
   parameter int PA_W     = 46,
   parameter int LEVELS   = 4,
   parameter int IDX_W    = 9,
   parameter int PAGE_LOG = 12,
   parameter int SUB_LOG  = 7,
   localparam int GPA_W     = PAGE_LOG + LEVELS * IDX_W,
   localparam int PFN_W     = PA_W - PAGE_LOG,
   localparam int SUB_IDX_W = PAGE_LOG - SUB_LOG,
   localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [GPA_W-1:SUB_LOG]  req_gpa,
   input  logic                    req_leaf_subprot,
   input  logic                    req_leaf_wr,
   input  logic                    cfg_subprot_en,
   input  logic [PFN_W-1:0]        cfg_root_pfn,
   output logic                    mem_req_valid,
   input  logic                    mem_req_ready,
   output logic [PA_W-1:0]         mem_req_addr,
   input  logic                    mem_rsp_valid,
   input  logic [63:0]             mem_rsp_data,
   output logic                    out_valid,
   output logic [2:0]              out_kind,
   output logic [63:0]             out_qual
);
   import subpg_pkg::*;

   // elaboration-time parameter checks
   if (PA_W <= PAGE_LOG || PA_W > 52) begin : g_bad_pa_w
      $error("PA_W must lie above PAGE_LOG and not exceed 52");
   end
   if (IDX_W + ENTRY_LOG != PAGE_LOG) begin : g_bad_idx_w
      $error("one table of 8-byte entries must fill exactly one page");
   end
   if (2 * (1 << SUB_IDX_W) != ENTRY_W) begin : g_bad_sub
      $error("leaf entry must hold two bits per sub-page");
   end
   if (GPA_W > 64 || LEVELS < 2) begin : g_bad_levels
      $error("LEVELS out of range");
   end

   localparam logic [LVL_W-1:0] TOP_LVL   = LVL_W'(LEVELS - 1);
   localparam logic [63:0]      QUAL_MISS = 64'd1 << MISS_QUAL_BIT;

   walk_state_e               state_q, state_d;
   logic [LVL_W-1:0]          lvl_q, lvl_d;
   logic [PFN_W-1:0]          pfn_q, pfn_d;
   logic [GPA_W-1:SUB_LOG]    gpa_q, gpa_d;
   logic                      fin;
   outcome_e                  fin_kind;
   logic                      out_valid_q;
   outcome_e                  out_kind_q;
   logic [63:0]               out_qual_q;

   logic                      dir_misconf, dir_present;
   logic [PFN_W-1:0]          dir_next;
   logic                      leaf_misconf, leaf_perm;

   subpg_entry_addr #(
      .PA_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .PAGE_LOG(PAGE_LOG)
   ) addr_i (
      .gpa_pg   (gpa_q[GPA_W-1:PAGE_LOG]),
      .lvl      (lvl_q),
      .base_pfn (pfn_q),
      .addr     (mem_req_addr)
   );

   subpg_dir_check #(
      .PA_W(PA_W), .PAGE_LOG(PAGE_LOG)
   ) dir_i (
      .ent      (mem_rsp_data),
      .misconf  (dir_misconf),
      .present  (dir_present),
      .next_pfn (dir_next)
   );

   subpg_leaf_check #(
      .SUB_IDX_W(SUB_IDX_W)
   ) leaf_i (
      .ent     (mem_rsp_data),
      .sub     (gpa_q[PAGE_LOG-1:SUB_LOG]),
      .misconf (leaf_misconf),
      .perm    (leaf_perm)
   );

   always_comb begin
      state_d  = state_q;
      lvl_d    = lvl_q;
      pfn_d    = pfn_q;
      gpa_d    = gpa_q;
      fin      = 1'b0;
      fin_kind = OUT_LEGACY;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               gpa_d = req_gpa;
               if (!(cfg_subprot_en && req_leaf_subprot)) begin
                  fin      = 1'b1;
                  fin_kind = OUT_LEGACY;
               end else if (req_leaf_wr) begin
                  fin      = 1'b1;
                  fin_kind = OUT_ALLOW;
               end else begin
                  state_d = ST_ISSUE;
                  lvl_d   = TOP_LVL;
                  pfn_d   = cfg_root_pfn;
               end
            end
         end
         ST_ISSUE: begin
            if (mem_req_ready) state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (mem_rsp_valid) begin
               if (lvl_q != '0) begin
                  // reserved bits take precedence over the present flag
                  if (dir_misconf) begin
                     fin      = 1'b1;
                     fin_kind = OUT_MISCONF;
                     state_d  = ST_IDLE;
                  end else if (!dir_present) begin
                     fin      = 1'b1;
                     fin_kind = OUT_MISS;
                     state_d  = ST_IDLE;
                  end else begin
                     pfn_d   = dir_next;
                     lvl_d   = lvl_q - LVL_W'(1);
                     state_d = ST_ISSUE;
                  end
               end else begin
                  fin     = 1'b1;
                  state_d = ST_IDLE;
                  if (leaf_misconf)   fin_kind = OUT_MISCONF;
                  else if (leaf_perm) fin_kind = OUT_ALLOW;
                  else                fin_kind = OUT_VIOLATE;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         lvl_q       <= '0;
         pfn_q       <= '0;
         gpa_q       <= '0;
         out_valid_q <= 1'b0;
         out_kind_q  <= OUT_LEGACY;
         out_qual_q  <= '0;
      end else begin
         state_q     <= state_d;
         lvl_q       <= lvl_d;
         pfn_q       <= pfn_d;
         gpa_q       <= gpa_d;
         out_valid_q <= fin;
         if (fin) out_kind_q <= fin_kind;
         out_qual_q  <= (fin && fin_kind == OUT_MISS) ? QUAL_MISS : '0;
      end
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign mem_req_valid = (state_q == ST_ISSUE);
   assign out_valid     = out_valid_q;
   assign out_kind      = out_kind_q;
   assign out_qual      = out_qual_q;
endmodule

// File: rtl/subpg_walker_chk.sv
// Protocol and outcome properties of subpg_walker.
module subpg_walker_chk #(
   parameter int PA_W = 46
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            req_leaf_subprot,
   input logic            req_leaf_wr,
   input logic            cfg_subprot_en,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [PA_W-1:0] mem_req_addr,
   input logic            out_valid,
   input logic [2:0]      out_kind,
   input logic [63:0]     out_qual
);
   import subpg_pkg::*;

   logic       acc;
   logic [1:0] pend_q;

   assign acc = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_q + 2'(acc) - 2'(out_valid);
   end

   a_r1_legacy_next: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !(cfg_subprot_en && req_leaf_subprot) |=> out_valid && out_kind == OUT_LEGACY);

   a_r2_writable_allow: assert property (@(posedge clk) disable iff (!rst_n)
      acc && cfg_subprot_en && req_leaf_subprot && req_leaf_wr |=> out_valid && out_kind == OUT_ALLOW);

   a_r3_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

   a_r4_zero_qual: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_kind != OUT_MISS |-> out_qual == 64'd0);

   a_r5_miss_qual: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_kind == OUT_MISS |-> out_qual == 64'h800);

   a_r8_one_per_req: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> pend_q == 2'd1);

   a_r8_accept_free: assert property (@(posedge clk) disable iff (!rst_n)
      acc |-> pend_q == 2'd0 || out_valid);

   a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
endmodule

bind subpg_walker subpg_walker_chk #(.PA_W(PA_W)) chk_i (
   .clk              (clk),
   .rst_n            (rst_n),
   .req_valid        (req_valid),
   .req_ready        (req_ready),
   .req_leaf_subprot (req_leaf_subprot),
   .req_leaf_wr      (req_leaf_wr),
   .cfg_subprot_en   (cfg_subprot_en),
   .mem_req_valid    (mem_req_valid),
   .mem_req_ready    (mem_req_ready),
   .mem_req_addr     (mem_req_addr),
   .out_valid        (out_valid),
   .out_kind         (out_kind),
   .out_qual         (out_qual)
);

// File: tb/subpg_walker_tb_top.sv
`timescale 1ns/1ps
module subpg_walker_tb_top;
   localparam int PA_W = 46;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid;
   logic              req_ready;
   logic [47:7]       req_gpa;
   logic              req_leaf_subprot;
   logic              req_leaf_wr;
   logic              cfg_subprot_en;
   logic [33:0]       cfg_root_pfn;
   logic              mem_req_valid;
   logic              mem_req_ready;
   logic [PA_W-1:0]   mem_req_addr;
   logic              mem_rsp_valid;
   logic [63:0]       mem_rsp_data;
   logic              out_valid;
   logic [2:0]        out_kind;
   logic [63:0]       out_qual;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   subpg_walker dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_gpa(req_gpa), .req_leaf_subprot(req_leaf_subprot), .req_leaf_wr(req_leaf_wr),
      .cfg_subprot_en(cfg_subprot_en), .cfg_root_pfn(cfg_root_pfn),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .out_valid(out_valid), .out_kind(out_kind),
      .out_qual(out_qual)
   );

   // ---------------- memory model ----------------
   logic [63:0]     mem [logic [PA_W-1:0]];
   logic [PA_W-1:0] rd_q [$];
   bit              stall_en = 0;
   bit              hold_bad = 0;
   int              scnt = 0;
   bit              rsp_pend = 0;
   logic [PA_W-1:0] rsp_addr;
   logic [PA_W-1:0] stall_addr;

   function automatic logic [63:0] rd_mem(logic [PA_W-1:0] a);
      return mem.exists(a) ? mem[a] : 64'd0;
   endfunction

   initial begin
      mem_req_ready = 1'b1;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
   end

   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      if (rsp_pend) begin
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = rd_mem(rsp_addr);
         rsp_pend      = 0;
      end
      if (mem_req_valid) begin
         if (stall_en && scnt < 3) begin
            if (scnt > 0 && mem_req_addr != stall_addr) hold_bad = 1;
            stall_addr    = mem_req_addr;
            mem_req_ready = 1'b0;
            scnt++;
         end else begin
            if (scnt > 0 && mem_req_addr != stall_addr) hold_bad = 1;
            mem_req_ready = 1'b1;
            scnt     = 0;
            rsp_pend = 1;
            rsp_addr = mem_req_addr;
            rd_q.push_back(mem_req_addr);
         end
      end else begin
         mem_req_ready = 1'b1;
      end
   end

   // ---------------- helpers ----------------
   function automatic logic [47:0] ga(int a, int b, int c, int d, int s);
      return {9'(a), 9'(b), 9'(c), 9'(d), 5'(s), 7'b0};
   endfunction

   function automatic logic [PA_W-1:0] ea(logic [33:0] pfn, int idx);
      return {pfn, 9'(idx), 3'b000};
   endfunction

   localparam logic [33:0] ROOT = 34'h100;

   task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // reference read sequence, from the address rule of R3
   task automatic ref_walk(input logic [47:0] g, output logic [PA_W-1:0] a [4], output int n);
      logic [33:0] pfn = ROOT;
      logic [63:0] e;
      n = 0;
      for (int lv = 3; lv >= 0; lv--) begin
         a[n] = ea(pfn, int'(g[12 + lv*9 +: 9]));
         n++;
         if (lv == 0) break;
         e = rd_mem(a[n-1]);
         if ((e & 64'hFFFF_C000_0000_0FFE) != 0 || !e[0]) break;
         pfn = e[45:12];
      end
   endtask

   task automatic run_req(input bit en, input bit sp, input bit wr, input logic [47:0] g,
                          output logic [2:0] k, output logic [63:0] q,
                          output int pulses, output bit busy_ok);
      rd_q.delete();
      @(negedge clk);
      cfg_subprot_en   = en;
      req_leaf_subprot = sp;
      req_leaf_wr      = wr;
      req_gpa          = g[47:7];
      req_valid        = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      pulses = 0; busy_ok = 1; k = '0; q = '0;
      for (int c = 0; c < 40; c++) begin
         if (out_valid) begin
            if (pulses == 0) begin k = out_kind; q = out_qual; end
            pulses++;
         end else if (pulses == 0 && req_ready) begin
            busy_ok = 0;
         end
         @(negedge clk);
      end
   endtask

   function automatic string tag_of(logic [2:0] k, int nrd);
      case (k)
         3'd0: return "R1";
         3'd1: return (nrd == 0) ? "R2" : "R7";
         3'd2: return "R7";
         3'd3: return "R5";
         default: return (nrd == 4) ? "R6" : "R4";
      endcase
   endfunction

   // {en, subprot, wr, gpa[47:0], kind, reads}
   localparam int NV = 21;
   localparam logic [56:0] VEC [NV] = '{
      {1'b0, 1'b1, 1'b0, ga(1,2,3,4,0),   3'd0, 3'd0},  // R1 enable off
      {1'b1, 1'b0, 1'b0, ga(1,2,3,4,0),   3'd0, 3'd0},  // R1 protect bit off
      {1'b0, 1'b1, 1'b1, ga(1,2,3,4,0),   3'd0, 3'd0},  // R1 wins over writable
      {1'b1, 1'b1, 1'b1, ga(1,2,3,4,1),   3'd1, 3'd0},  // R2 writable
      {1'b1, 1'b1, 1'b1, ga(7,0,0,0,0),   3'd1, 3'd0},  // R2 no walk even where table empty
      {1'b1, 1'b1, 1'b0, ga(1,2,3,4,0),   3'd1, 3'd4},  // R7 sub 0
      {1'b1, 1'b1, 1'b0, ga(1,2,3,4,1),   3'd2, 3'd4},  // R7 sub 1
      {1'b1, 1'b1, 1'b0, ga(1,2,3,4,5),   3'd1, 3'd4},  // R7 sub 5
      {1'b1, 1'b1, 1'b0, ga(1,2,3,4,31),  3'd1, 3'd4},  // R7 top sub-page
      {1'b1, 1'b1, 1'b0, ga(1,2,3,4,30),  3'd2, 3'd4},  // R7 sub 30
      {1'b1, 1'b1, 1'b0, ga(7,0,0,0,0),   3'd3, 3'd1},  // R5 miss at L4
      {1'b1, 1'b1, 1'b0, ga(1,9,0,0,0),   3'd3, 3'd2},  // R5 miss at L3
      {1'b1, 1'b1, 1'b0, ga(1,2,10,0,0),  3'd3, 3'd3},  // R5 miss at L2
      {1'b1, 1'b1, 1'b0, ga(511,0,0,0,0), 3'd3, 3'd1},  // R3 last index
      {1'b1, 1'b1, 1'b0, ga(1,5,0,0,0),   3'd4, 3'd2},  // R4 reserved low, not present
      {1'b1, 1'b1, 1'b0, ga(6,0,0,0,0),   3'd4, 3'd1},  // R4 lowest high reserved bit
      {1'b1, 1'b1, 1'b0, ga(8,0,0,0,0),   3'd3, 3'd2},  // R3 highest address bit kept
      {1'b1, 1'b1, 1'b0, ga(1,2,6,0,0),   3'd4, 3'd3},  // R4 bit 63 at L2
      {1'b1, 1'b1, 1'b0, ga(1,2,3,7,0),   3'd4, 3'd4},  // R6 bit 1
      {1'b1, 1'b1, 1'b0, ga(1,2,3,8,0),   3'd4, 3'd4},  // R6 bit 63
      {1'b1, 1'b1, 1'b0, ga(1,2,3,9,3),   3'd2, 3'd4}   // R7 empty leaf
   };

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [2:0]      k;
      logic [63:0]     q;
      int              pulses;
      bit              busy_ok;
      logic [PA_W-1:0] ra [4];
      int              rn;
      bit              same;

      rst_n = 1'b0; req_valid = 1'b0; req_gpa = '0; req_leaf_subprot = 1'b0;
      req_leaf_wr = 1'b0; cfg_subprot_en = 1'b0; cfg_root_pfn = ROOT;

      // table contents
      mem[ea(ROOT, 1)]     = 64'h0000_0000_0020_0001;
      mem[ea(ROOT, 6)]     = 64'h0000_4000_0020_0001;
      mem[ea(ROOT, 8)]     = 64'h0000_2000_0000_0001;
      mem[ea(34'h200, 2)]  = 64'h0000_0000_0030_0001;
      mem[ea(34'h200, 5)]  = 64'h0000_0000_0000_0010;
      mem[ea(34'h300, 3)]  = 64'h0000_0000_0040_0001;
      mem[ea(34'h300, 6)]  = 64'h8000_0000_0040_0001;
      mem[ea(34'h400, 4)]  = 64'h4000_0000_0000_0401;
      mem[ea(34'h400, 7)]  = 64'h0000_0000_0000_0003;
      mem[ea(34'h400, 8)]  = 64'h8000_0000_0000_0001;

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(req_ready == 1'b1,     "R10", "req_ready in reset",     64'(req_ready), 64'd1);
      chk(out_valid == 1'b0,     "R10", "out_valid in reset",     64'(out_valid), 64'd0);
      chk(mem_req_valid == 1'b0, "R10", "mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && out_valid == 1'b0, "R10", "idle after reset",
          {62'd0, req_ready, out_valid}, 64'd2);

      for (int v = 0; v < NV; v++) begin
         logic [47:0] g;
         logic [2:0]  ek;
         int          en;
         string       tg;
         g  = VEC[v][53:6];
         ek = VEC[v][5:3];
         en = int'(VEC[v][2:0]);
         tg = tag_of(ek, en);
         run_req(VEC[v][56], VEC[v][55], VEC[v][54], g, k, q, pulses, busy_ok);
         chk(pulses == 1, "R8", $sformatf("vec %0d pulses", v), 64'(pulses), 64'd1);
         chk(k == ek, tg, $sformatf("vec %0d kind", v), 64'(k), 64'(ek));
         chk(q == ((ek == 3'd3) ? 64'h800 : 64'd0), (ek == 3'd3) ? "R5" : "R4",
             $sformatf("vec %0d qual", v), q, (ek == 3'd3) ? 64'h800 : 64'd0);
         chk(rd_q.size() == en, "R3", $sformatf("vec %0d read count", v),
             64'(rd_q.size()), 64'(en));
         if (en > 0) begin
            ref_walk(g, ra, rn);
            same = (rn == en);
            for (int i = 0; i < rd_q.size() && i < 4; i++)
               if (rd_q[i] != ra[i]) same = 0;
            chk(same, "R3", $sformatf("vec %0d read addresses", v),
                64'(rd_q.size() > 0 ? rd_q[0] : '0), 64'(ra[0]));
            chk(busy_ok, "R8", $sformatf("vec %0d ready low while walking", v),
                64'(busy_ok), 64'd1);
         end
      end

      // back-pressure on every table read
      stall_en = 1;
      run_req(1'b1, 1'b1, 1'b0, ga(1,2,3,4,5), k, q, pulses, busy_ok);
      stall_en = 0;
      ref_walk(ga(1,2,3,4,5), ra, rn);
      chk(k == 3'd1 && pulses == 1, "R9", "stalled walk outcome", 64'(k), 64'd1);
      chk(!hold_bad, "R9", "address held while not accepted", 64'(hold_bad), 64'd0);
      chk(rd_q.size() == 4 && rd_q[3] == ra[3], "R9", "stalled walk leaf address",
          64'(rd_q.size() == 4 ? rd_q[3] : '0), 64'(ra[3]));

      done = 1;
      summary();
      $finish;
   end
endmodule